// File: doc/BRIEF.md
# Auxiliary Register Arithmetic Unit

This block generates indirect data-memory addresses for a DSP data path. It keeps a bank of eight 16-bit address registers, a 3-bit selector that names the current register, and a 3-bit saved copy of the previous selector value. When an indirect access is issued, the current register's value leaves the block as the operand address. At the clock edge that ends the same cycle, the register is modified by the chosen rule: step up or down by one, add or subtract register 0 as an index, or do that add or subtract with reverse-carry propagation for FFT bit-reversed addressing. The selector can be reloaded in that same instruction. Its old value is then saved in the backup.

Side ports give direct access to the bank. A write port loads any register and a read port returns any register. An immediate add or subtract works on the current register. A zero flag combined with a loop-branch decrement supports counted loops. A compare output tests the current register against register 0. Instruction decoding and the data memory are outside this block.

Top module: `aru_top`

## Requirements
- R1: After a synchronous active-low reset, all eight registers, `ptr_out` and `buf_out` are zero.
- R2: `addr_out` always shows the current register, which is the one selected by `ptr_out`. A modification becomes visible only after the next rising edge. The `ind_mode` codes are: 0 no change, 1 plus one, 2 minus one, 3 plus register 0, 4 minus register 0, 5 reverse-carry plus register 0, 6 reverse-carry minus register 0, 7 no change. With `ind_en` low the command has no effect.
- R3: Modes 1 and 2 step the current register by one, modulo 2^16 (0xFFFF+1 = 0, 0-1 = 0xFFFF).
- R4: Modes 3 and 4 add or subtract the value of register 0, modulo 2^16.
- R5: Modes 5 and 6 produce rev(rev(cur) ± rev(reg0)), where rev reverses all 16 bits. Starting from 0 with register 0 = 4, mode 5 visits 0,4,2,6,1,5,3,7,0. From 0, mode 6 with register 0 = 4 gives 7.
- R6: Applying mode 3 while the current register is register 0 doubles register 0.
- R7: When `ptr_ld` is high, the modification in that cycle targets the register selected by the old selector. After the edge, `ptr_out` equals `ptr_new` and `buf_out` equals the old `ptr_out`. Without `ptr_ld`, both hold.
- R8: `wr_en` loads `wr_data` into register `wr_sel`. If that register is also being modified in the same cycle, the write wins.
- R9: `adk_en` adds (`adk_sub`=0) or subtracts (`adk_sub`=1) the zero-extended 8-bit `adk_imm` to or from the current register.
- R10: `zero_flag` is 1 exactly when the current register is 0. `loop_en` decrements the current register by one.
- R11: `tc` compares the current register (A) with register 0 (B) as unsigned values. `cmp_mode` 0 gives A==B, 1 gives A<B, 2 gives A>B, 3 gives A!=B.
- R12: When several update commands are raised together, an indirect modify (`ind_en`) wins over `loop_en`, which wins over `adk_en`.
- R13: `rd_data` returns register `rd_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ind_en | input | 1 | Indirect access this cycle |
| ind_mode | input | 3 | Modify rule code |
| ptr_ld | input | 1 | Reload selector this cycle |
| ptr_new | input | 3 | New selector value |
| addr_out | output | 16 | Operand address (current register) |
| wr_en | input | 1 | Direct register load |
| wr_sel | input | 3 | Register to load |
| wr_data | input | 16 | Load value |
| rd_sel | input | 3 | Register to read |
| rd_data | output | 16 | Read value |
| adk_en | input | 1 | Immediate add/subtract on current register |
| adk_sub | input | 1 | 1 selects subtract |
| adk_imm | input | 8 | Unsigned immediate |
| loop_en | input | 1 | Loop-branch decrement |
| zero_flag | output | 1 | Current register is zero |
| cmp_mode | input | 2 | Compare condition |
| tc | output | 1 | Compare result |
| ptr_out | output | 3 | Current selector |
| buf_out | output | 3 | Saved previous selector |

## Verification
Two functions can act in the same cycle: a modify of the current register and a selector reload. The bench raises both in one vector, then reads every register through the read port after the edge. The modified register must be the one named by the old selector, and `buf_out` must hold that old value. A second collision, where a direct load targets the register being modified, is forced on purpose, and the loaded value must survive. Every result is checked against a bench model whose reverse-carry arithmetic runs a bitwise carry from the top bit downward.

// File: rtl/aru_pkg.sv
// Shared codes for the address register unit.
// Assumes a 3-bit modify code and a 2-bit compare code.
package aru_pkg;
    typedef enum logic [2:0] {
        AM_HOLD  = 3'd0,
        AM_INC   = 3'd1,
        AM_DEC   = 3'd2,
        AM_ADDX  = 3'd3,
        AM_SUBX  = 3'd4,
        AM_RADDX = 3'd5,
        AM_RSUBX = 3'd6,
        AM_SPARE = 3'd7
    } amod_e;

    typedef enum logic [1:0] {
        CM_EQ = 2'd0,
        CM_LT = 2'd1,
        CM_GT = 2'd2,
        CM_NE = 2'd3
    } cmode_e;
endpackage

// File: rtl/aru_revcarry.sv
// Reverse-carry adder/subtractor: y = rev(rev(a) +/- rev(b)).
// Carries travel from the MSB toward the LSB. Assumes W >= 2.
module aru_revcarry #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [W-1:0] rs;

    // Bit reversal of both operands and of the result.
    for (genvar k = 0; k < W; k++) begin : g_rev
        assign ra[k]  = a_i[W-1-k];
        assign rb[k]  = b_i[W-1-k];
        assign y_o[k] = rs[W-1-k];
    end

    // Ordinary arithmetic in the reversed domain.
    assign rs = sub_i ? (ra - rb) : (ra + rb);
endmodule

// File: rtl/aru_modify.sv
// Next-value generator for the indirect modify rules.
// Assumes cur_i is the current register and idx_i is register 0.
// Unused codes leave the value unchanged.
module aru_modify
    import aru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] idx_i,
    input  logic [2:0]   mode_i,
    output logic [W-1:0] next_o,
    output logic         chg_o
);
    logic [W-1:0] rev_val;
    logic         rev_sub;

    assign rev_sub = (mode_i == AM_RSUBX);

    aru_revcarry #(.W(W)) u_rev (
        .a_i   (cur_i),
        .b_i   (idx_i),
        .sub_i (rev_sub),
        .y_o   (rev_val)
    );

    // Select the modified value by rule code.
    always_comb begin
        chg_o  = 1'b1;
        next_o = cur_i;
        case (mode_i)
            AM_INC:   next_o = cur_i + W'(1);
            AM_DEC:   next_o = cur_i - W'(1);
            AM_ADDX:  next_o = cur_i + idx_i;
            AM_SUBX:  next_o = cur_i - idx_i;
            AM_RADDX,
            AM_RSUBX: next_o = rev_val;
            default:  chg_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/aru_compare.sv
// Unsigned comparison of the current register against register 0.
// Assumes the 2-bit condition codes from aru_pkg.
module aru_compare
    import aru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   mode_i,
    output logic         tc_o
);
    // Evaluate the selected condition.
    always_comb begin
        case (mode_i)
            CM_EQ:   tc_o = (a_i == b_i);
            CM_LT:   tc_o = (a_i <  b_i);
            CM_GT:   tc_o = (a_i >  b_i);
            default: tc_o = (a_i != b_i);
        endcase
    end
endmodule

// File: rtl/aru_top.sv
// Address register unit: a register bank, a selector, a selector backup,
// post-modify indirect addressing and side access ports.
// Assumes NREG is a power of two. Update priority is ind > loop > imm.
// A direct write overrides an update to the same register.
module aru_top
    import aru_pkg::*;
#(
    parameter int W     = 16,
    parameter int NREG  = 8,
    parameter int IMM_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ind_en,
    input  logic [2:0]               ind_mode,
    input  logic                     ptr_ld,
    input  logic [$clog2(NREG)-1:0]  ptr_new,
    output logic [W-1:0]             addr_out,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_sel,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(NREG)-1:0]  rd_sel,
    output logic [W-1:0]             rd_data,
    input  logic                     adk_en,
    input  logic                     adk_sub,
    input  logic [IMM_W-1:0]         adk_imm,
    input  logic                     loop_en,
    output logic                     zero_flag,
    input  logic [1:0]               cmp_mode,
    output logic                     tc,
    output logic [$clog2(NREG)-1:0]  ptr_out,
    output logic [$clog2(NREG)-1:0]  buf_out
);
    localparam int PW = $clog2(NREG);

    logic [W-1:0]  ar_q [NREG];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] buf_q;
    logic [W-1:0]  cur_val;
    logic [W-1:0]  ar0_val;
    logic [W-1:0]  mod_val;
    logic          mod_chg;
    logic [W-1:0]  imm_ext;
    logic [W-1:0]  upd_val;
    logic          upd_en;

    assign cur_val = ar_q[ptr_q];
    assign ar0_val = ar_q[0];
    assign imm_ext = {{(W-IMM_W){1'b0}}, adk_imm};

    aru_modify #(.W(W)) u_mod (
        .cur_i  (cur_val),
        .idx_i  (ar0_val),
        .mode_i (ind_mode),
        .next_o (mod_val),
        .chg_o  (mod_chg)
    );

    aru_compare #(.W(W)) u_cmp (
        .a_i    (cur_val),
        .b_i    (ar0_val),
        .mode_i (cmp_mode),
        .tc_o   (tc)
    );

    // Choose the arithmetic update for the current register by priority.
    always_comb begin
        upd_en  = 1'b0;
        upd_val = cur_val;
        if (ind_en) begin
            upd_en  = mod_chg;
            upd_val = mod_val;
        end else if (loop_en) begin
            upd_en  = 1'b1;
            upd_val = cur_val - W'(1);
        end else if (adk_en) begin
            upd_en  = 1'b1;
            upd_val = adk_sub ? (cur_val - imm_ext) : (cur_val + imm_ext);
        end
    end

    // One storage process per register: direct load beats update.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                ar_q[i] <= '0;
            else if (wr_en && (wr_sel == PW'(i)))
                ar_q[i] <= wr_data;
            else if (upd_en && (ptr_q == PW'(i)))
                ar_q[i] <= upd_val;
        end
    end

    // Selector reload, saving the previous selector in the backup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            buf_q <= '0;
        end else if (ptr_ld) begin
            buf_q <= ptr_q;
            ptr_q <= ptr_new;
        end
    end

    assign addr_out  = cur_val;
    assign rd_data   = ar_q[rd_sel];
    assign zero_flag = (cur_val == '0);
    assign ptr_out   = ptr_q;
    assign buf_out   = buf_q;
endmodule

// File: rtl/aru_checker.sv
// Temporal checks on the address register unit, attached by bind.
// Assumes the port behaviour of aru_top and its internal ar0_val.
module aru_checker #(
    parameter int W  = 16,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ind_en,
    input logic [2:0]    ind_mode,
    input logic          ptr_ld,
    input logic [PW-1:0] ptr_new,
    input logic          wr_en,
    input logic [PW-1:0] wr_sel,
    input logic [W-1:0]  wr_data,
    input logic          loop_en,
    input logic [W-1:0]  addr_out,
    input logic [PW-1:0] ptr_out,
    input logic [PW-1:0] buf_out,
    input logic [W-1:0]  ar0_val
);
    logic quiet;
    assign quiet = !ptr_ld && !(wr_en && (wr_sel == ptr_out));

    p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |=> (ptr_out == $past(ptr_new)) && (buf_out == $past(ptr_out)));

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_ld |=> $stable(ptr_out) && $stable(buf_out));

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ind_en && ind_mode == 3'd1) |=> addr_out == W'($past(addr_out) + 1'b1));

    p_add_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ind_en && ind_mode == 3'd3) |=> addr_out == W'($past(addr_out) + $past(ar0_val)));

    p_loop_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !ind_en && loop_en) |=> addr_out == W'($past(addr_out) - 1'b1));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_ld && wr_sel == ptr_out) |=> addr_out == $past(wr_data));
endmodule

bind aru_top aru_checker #(.W(W), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ind_en   (ind_en),
    .ind_mode (ind_mode),
    .ptr_ld   (ptr_ld),
    .ptr_new  (ptr_new),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .loop_en  (loop_en),
    .addr_out (addr_out),
    .ptr_out  (ptr_out),
    .buf_out  (buf_out),
    .ar0_val  (ar0_val)
);

// File: tb/aru_top_tb.sv
// Self-checking bench: a vector table walked against a reference model,
// then directed tests for reset, bit-reversed order, wraps and collisions.
module aru_top_tb;
    localparam int CLK_PERIOD = 20;
    localparam int NV = 16;
    // {ind_en, mode[2:0], ptr_ld, ptr_new[2:0]}
    localparam logic [7:0] VEC [NV] = '{
        8'b1_001_0_000, 8'b1_010_0_000, 8'b1_011_0_000, 8'b1_100_0_000,
        8'b1_101_0_000, 8'b1_110_0_000, 8'b1_001_1_101, 8'b1_011_1_010,
        8'b1_000_1_000, 8'b1_011_0_000, 8'b1_110_1_111, 8'b1_010_0_000,
        8'b1_111_0_000, 8'b0_001_0_000, 8'b1_101_1_100, 8'b1_100_0_000
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ind_en = 0;
    logic [2:0]  ind_mode = 0;
    logic        ptr_ld = 0;
    logic [2:0]  ptr_new = 0;
    logic [15:0] addr_out;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic [2:0]  rd_sel = 0;
    logic [15:0] rd_data;
    logic        adk_en = 0;
    logic        adk_sub = 0;
    logic [7:0]  adk_imm = 0;
    logic        loop_en = 0;
    logic        zero_flag;
    logic [1:0]  cmp_mode = 0;
    logic        tc;
    logic [2:0]  ptr_out;
    logic [2:0]  buf_out;

    int errors = 0;
    int checks = 0;
    logic [15:0] m_ar [8];
    logic [2:0]  m_ptr;
    logic [2:0]  m_buf;

    always #(CLK_PERIOD/2) clk = ~clk;

    aru_top u_dut (.*);

    // Compare one value and log a failure line.
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reverse-carry add/sub, carry rippling from bit 15 down to bit 0.
    function automatic logic [15:0] rc_op(logic [15:0] a, logic [15:0] b, logic sub);
        logic [15:0] y;
        logic c = sub;
        logic [15:0] bb = sub ? ~b : b;
        for (int i = 15; i >= 0; i--) begin
            y[i] = a[i] ^ bb[i] ^ c;
            c = (a[i] & bb[i]) | (a[i] & c) | (bb[i] & c);
        end
        return y;
    endfunction

    function automatic logic exp_tc(logic [15:0] a, logic [15:0] b, logic [1:0] m);
        case (m)
            2'd0: return a == b;
            2'd1: return a < b;
            2'd2: return a > b;
            default: return a != b;
        endcase
    endfunction

    // Reference model applied at each rising edge.
    task automatic model_update();
        logic [15:0] cur = m_ar[m_ptr];
        logic [15:0] v = cur;
        logic en = 1'b1;
        if (!rst_n) begin
            foreach (m_ar[i]) m_ar[i] = '0;
            m_ptr = 0; m_buf = 0;
            return;
        end
        if (ind_en) begin
            case (ind_mode)
                3'd1: v = cur + 16'd1;
                3'd2: v = cur - 16'd1;
                3'd3: v = cur + m_ar[0];
                3'd4: v = cur - m_ar[0];
                3'd5: v = rc_op(cur, m_ar[0], 1'b0);
                3'd6: v = rc_op(cur, m_ar[0], 1'b1);
                default: en = 1'b0;
            endcase
        end else if (loop_en) v = cur - 16'd1;
        else if (adk_en) v = adk_sub ? cur - {8'd0, adk_imm} : cur + {8'd0, adk_imm};
        else en = 1'b0;
        if (en) m_ar[m_ptr] = v;
        if (wr_en) m_ar[wr_sel] = wr_data;
        if (ptr_ld) begin m_buf = m_ptr; m_ptr = ptr_new; end
    endtask

    task automatic clr();
        ind_en = 0; ind_mode = 0; ptr_ld = 0; ptr_new = 0; wr_en = 0;
        adk_en = 0; adk_sub = 0; adk_imm = 0; loop_en = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        #1 clr();
    endtask

    task automatic wr(logic [2:0] s, logic [15:0] d);
        wr_en = 1; wr_sel = s; wr_data = d; tick();
    endtask

    task automatic set_ptr(logic [2:0] p);
        ptr_ld = 1; ptr_new = p; tick();
    endtask

    // Read every register through the read port and compare.
    task automatic check_all(string req);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i); #1;
            check(req, rd_data, m_ar[i]);
        end
        check({req, " ptr"}, ptr_out, m_ptr);
        check({req, " buf"}, buf_out, m_buf);
    endtask

    function automatic string req_of(logic [7:0] v);
        if (v[3]) return "R7";
        if (!v[7]) return "R2";
        case (v[6:4])
            3'd1, 3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            default: return "R2";
        endcase
    endfunction

    logic done = 0;
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] seq [8] = '{16'd0, 16'd4, 16'd2, 16'd6, 16'd1, 16'd5, 16'd3, 16'd7};
        clr();
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1: reset state
        check_all("R1");
        check("R10 zero after reset", zero_flag, 1'b1);

        // Preload distinct values for the table walk.
        wr(3'd0, 16'h0013); wr(3'd1, 16'h1234); wr(3'd2, 16'hFFF0);
        wr(3'd4, 16'h8001); wr(3'd5, 16'h0100); wr(3'd7, 16'h00A5);
        set_ptr(3'd1);
        check_all("R13");

        for (int n = 0; n < NV; n++) begin
            {ind_en, ind_mode, ptr_ld, ptr_new} = VEC[n];
            #1 check("R2 addr", addr_out, m_ar[m_ptr]);
            tick();
            check_all(req_of(VEC[n]));
        end

        // R6: index mode on register 0 itself doubles it.
        set_ptr(3'd0);
        wr(3'd0, 16'h0021);
        ind_en = 1; ind_mode = 3'd3; tick();
        rd_sel = 0; #1 check("R6", rd_data, 16'h0042);

        // R5: 8-point bit-reversed order with index 4.
        wr(3'd0, 16'd4); wr(3'd3, 16'd0); set_ptr(3'd3);
        for (int k = 0; k < 8; k++) begin
            #1 check("R5 seq", addr_out, seq[k]);
            ind_en = 1; ind_mode = 3'd5; tick();
        end
        #1 check("R5 seq end", addr_out, 16'd0);
        ind_en = 1; ind_mode = 3'd6; tick();
        #1 check("R5 rsub", addr_out, 16'd7);

        // R3: wraps.
        wr(3'd3, 16'hFFFF); ind_en = 1; ind_mode = 3'd1; tick();
        #1 check("R3 wrap up", addr_out, 16'h0000);
        ind_en = 1; ind_mode = 3'd2; tick();
        #1 check("R3 wrap down", addr_out, 16'hFFFF);

        // R10: zero flag and loop decrement.
        wr(3'd3, 16'd1);
        #1 check("R10 nonzero", zero_flag, 1'b0);
        loop_en = 1; tick();
        #1 check("R10 dec", addr_out, 16'd0);
        check("R10 zero", zero_flag, 1'b1);

        // R9: immediate add and subtract.
        adk_en = 1; adk_imm = 8'hF0; tick();
        #1 check("R9 add", addr_out, 16'h00F0);
        adk_en = 1; adk_sub = 1; adk_imm = 8'hF1; tick();
        #1 check("R9 sub", addr_out, 16'hFFFF);

        // R11: compare against register 0 (=4).
        foreach (seq[k]) begin
            wr(3'd3, seq[k]);
            for (int m = 0; m < 4; m++) begin
                cmp_mode = 2'(m); #1;
                check("R11", tc, exp_tc(seq[k], 16'd4, 2'(m)));
            end
        end

        // R8: direct write to the register being modified wins.
        wr_en = 1; wr_sel = 3'd3; wr_data = 16'hBEEF; ind_en = 1; ind_mode = 3'd1; tick();
        #1 check("R8", addr_out, 16'hBEEF);

        // R12: ind beats loop beats imm.
        ind_en = 1; ind_mode = 3'd1; loop_en = 1; adk_en = 1; adk_imm = 8'h10; tick();
        #1 check("R12 ind", addr_out, 16'hBEF0);
        loop_en = 1; adk_en = 1; adk_imm = 8'h10; tick();
        #1 check("R12 loop", addr_out, 16'hBEEF);

        // R7: reload plus modify in one cycle.
        ind_en = 1; ind_mode = 3'd2; ptr_ld = 1; ptr_new = 3'd6; tick();
        check_all("R7");
        check("R7 old reg", m_ar[3], 16'hBEEE);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule